// File: doc/BRIEF.md
# Divider-Change Watchdog with Recovery Pair

This block supervises a programmable clock synthesizer whose output frequency comes from an N/M divider pair. Software writes the dividers through a small register port. Every write to a divider register raises a one-cycle load strobe towards the synthesizer. A write to the normal pair also arms a countdown. If software does not confirm the new setting in time by clearing the enable, the countdown expires and the block records a sticky timeout flag. It can then optionally fall back to a stored recovery divider pair and fire a system reset pulse.

The countdown is counted in prescaler ticks. One select bit chooses a short or a long tick, each given in clock cycles by a parameter. The 5-bit timeout field value v gives v+1 ticks. A separate enable fires the reset pulse after any frequency change. The recovery pair stays active until software writes the normal pair again.

Top module: `fcwd_top`

## Requirements
- R1: After reset all registers, the load strobe, the status flag and the reset pulse are 0, and the active divider pair reads 0/0.
- R2: A write to the normal N register (address 0), the normal M register (1), the recovery N register (2) or the recovery M register (3) raises `freq_load` for exactly the one cycle after the write edge. Writes to other addresses do not raise it.
- R3: With watchdog enable (control bit 1) set, a write to normal N or M arms the countdown. The status flag rises after exactly (v+1)*T cycles from the write edge. Here v is the timeout field (address 5, bits 4:0), and T is the short tick when control bit 2 is 0 and the long tick when it is 1.
- R4: While the watchdog enable is 0 no countdown runs. Clearing it mid-count stops the count, and the next arm starts again from the full value.
- R5: The status flag reads back as bit 0 of address 6. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R6: With reset-on-timeout (control bit 3) set, `sys_rst_pulse` is high for RST_CYC cycles, starting the cycle after the expiry edge.
- R7: With reset-on-change (control bit 4) set, `sys_rst_pulse` is high for RST_CYC cycles, starting the cycle after a divider write.
- R8: With recovery select (control bit 0) set, expiry makes the recovery pair the active pair and raises `freq_load` once. With it clear, the normal pair stays active.
- R9: A write to normal N or M makes the normal pair active again.
- R10: After an expiry the countdown stays idle until the next write to a normal divider register.
- R11: Registers read back what was written, truncated to their widths: N 8 bits, M 7 bits, control 5 bits, timeout 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| div_n | output | 8 | Active N divider value |
| div_m | output | 7 | Active M divider value |
| freq_load | output | 1 | One-cycle frequency load strobe |
| wd_status | output | 1 | Sticky timeout flag |
| sys_rst_pulse | output | 1 | Reset pulse output |

## Verification
A countdown that is off by one tick, or a prescaler that restarts wrongly, moves the rise of `wd_status` away from the exact (v+1)*T cycle. The sweep over every timeout value with both tick lengths catches that on the first affected value. A stuck recovery flag or a wrong arm flag shows on `div_n`/`div_m` or as a missing or extra timeout within one tick of the expected edge. A wrong pulse counter shows as a `sys_rst_pulse` that is too short or too long, visible within RST_CYC+1 cycles.

// File: rtl/fcwd_pkg.sv
`timescale 1ns/1ps
package fcwd_pkg;
   typedef enum logic [2:0] {
      A_NRM_N = 3'd0,
      A_NRM_M = 3'd1,
      A_RCV_N = 3'd2,
      A_RCV_M = 3'd3,
      A_CTRL  = 3'd4,
      A_TMO   = 3'd5,
      A_STAT  = 3'd6
   } reg_addr_e;

   // control register, bit 0 is rcv_sel
   typedef struct packed {
      logic rst_chg;
      logic rst_to;
      logic pre_long;
      logic wd_en;
      logic rcv_sel;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/fcwd_regs.sv
`timescale 1ns/1ps
module fcwd_regs
   import fcwd_pkg::*;
#(
   parameter int N_W   = 8,
   parameter int M_W   = 7,
   parameter int TMO_W = 5,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       addr,
   input  logic [DW-1:0]    wdata,
   input  logic             sts,
   output logic [DW-1:0]    rdata,
   output logic [N_W-1:0]   nrm_n,
   output logic [M_W-1:0]   nrm_m,
   output logic [N_W-1:0]   rcv_n,
   output logic [M_W-1:0]   rcv_m,
   output ctl_t             ctl,
   output logic [TMO_W-1:0] tmo,
   output logic             wr_nrm,
   output logic             wr_rcv,
   output logic             sts_clr
);
   initial begin
      assert (DW >= N_W && DW >= M_W && DW >= TMO_W && DW >= CTL_W)
         else $fatal(1, "fcwd_regs: data width too small");
   end

   assign wr_nrm  = we && (addr == A_NRM_N || addr == A_NRM_M);
   assign wr_rcv  = we && (addr == A_RCV_N || addr == A_RCV_M);
   assign sts_clr = we && (addr == A_STAT) && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nrm_n <= '0;
         nrm_m <= '0;
         rcv_n <= '0;
         rcv_m <= '0;
         ctl   <= '0;
         tmo   <= '0;
      end else if (we) begin
         case (addr)
            A_NRM_N: nrm_n <= wdata[N_W-1:0];
            A_NRM_M: nrm_m <= wdata[M_W-1:0];
            A_RCV_N: rcv_n <= wdata[N_W-1:0];
            A_RCV_M: rcv_m <= wdata[M_W-1:0];
            A_CTRL:  ctl   <= ctl_t'(wdata[CTL_W-1:0]);
            A_TMO:   tmo   <= wdata[TMO_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_NRM_N: rdata = DW'(nrm_n);
         A_NRM_M: rdata = DW'(nrm_m);
         A_RCV_N: rdata = DW'(rcv_n);
         A_RCV_M: rdata = DW'(rcv_m);
         A_CTRL:  rdata = DW'(ctl);
         A_TMO:   rdata = DW'(tmo);
         A_STAT:  rdata = DW'(sts);
         default: rdata = '0;
      endcase
   end

   a_r11_tmo_written: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_TMO) |=> (tmo == $past(wdata[TMO_W-1:0])));
endmodule

// File: rtl/fcwd_prescaler.sv
`timescale 1ns/1ps
module fcwd_prescaler #(
   parameter int TICK_SHORT = 1500000,
   parameter int TICK_LONG  = 25000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic long_sel,
   output logic tick
);
   localparam int MAXT = (TICK_SHORT > TICK_LONG) ? TICK_SHORT : TICK_LONG;
   localparam int PW   = (MAXT < 2) ? 1 : $clog2(MAXT);

   initial begin
      assert (TICK_SHORT >= 1 && TICK_LONG >= 1)
         else $fatal(1, "fcwd_prescaler: tick length must be at least one cycle");
   end

   logic [PW-1:0] pc;
   logic [PW-1:0] last;

   generate
      if (TICK_SHORT == TICK_LONG) begin : g_one_len
         assign last = PW'(TICK_SHORT - 1);
      end else begin : g_two_len
         assign last = long_sel ? PW'(TICK_LONG - 1) : PW'(TICK_SHORT - 1);
      end
   endgenerate

   assign tick = run && !restart && (pc >= last);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) pc <= '0;
      else if (pc >= last)           pc <= '0;
      else                           pc <= pc + PW'(1);
   end

   a_r4_idle_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pc == '0));
endmodule

// File: rtl/fcwd_timer.sv
`timescale 1ns/1ps
module fcwd_timer #(
   parameter int TMO_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wd_en,
   input  logic             arm,
   input  logic [TMO_W-1:0] tmo,
   input  logic             tick,
   input  logic             sts_clr,
   output logic             armed,
   output logic             expire,
   output logic             sts
);
   localparam int CW = TMO_W + 1;
   localparam logic [CW-1:0] ONE = CW'(1);

   initial begin
      assert (TMO_W >= 1) else $fatal(1, "fcwd_timer: timeout width must be positive");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] reload;

   assign reload = {1'b0, tmo} + ONE;
   assign expire = armed && wd_en && tick && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (!wd_en) begin
         armed <= 1'b0;
         cnt   <= reload;
      end else if (arm) begin
         armed <= 1'b1;
         cnt   <= reload;
      end else if (expire) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (armed && tick) begin
         cnt   <= cnt - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       sts <= 1'b0;
      else if (expire)  sts <= 1'b1;
      else if (sts_clr) sts <= 1'b0;
   end

   a_r3_status_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> sts);
   a_r5_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr && !expire) |=> !sts);
   a_r10_disarm_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !arm) |=> !armed);
   a_r3_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cnt != '0));
endmodule

// File: rtl/fcwd_pulse.sv
`timescale 1ns/1ps
module fcwd_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pulse
);
   initial begin
      assert (LEN >= 1) else $fatal(1, "fcwd_pulse: length must be positive");
   end

   generate
      if (LEN == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= req;
         end
      end else begin : g_counted
         localparam int CW = $clog2(LEN + 1);
         logic [CW-1:0] left;
         always_ff @(posedge clk) begin
            if (!rst_n)             left <= '0;
            else if (req)           left <= CW'(LEN);
            else if (left != '0)    left <= left - CW'(1);
         end
         assign pulse = (left != '0);
      end
   endgenerate

   a_r6_pulse_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> pulse);
endmodule

// File: rtl/fcwd_top.sv
`timescale 1ns/1ps
module fcwd_top
   import fcwd_pkg::*;
#(
   parameter int N_W        = 8,
   parameter int M_W        = 7,
   parameter int TMO_W      = 5,
   parameter int DW         = 8,
   parameter int TICK_SHORT = 1500000,
   parameter int TICK_LONG  = 25000000,
   parameter int RST_CYC    = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [2:0]     cfg_addr,
   input  logic [DW-1:0]  cfg_wdata,
   output logic [DW-1:0]  cfg_rdata,
   output logic [N_W-1:0] div_n,
   output logic [M_W-1:0] div_m,
   output logic           freq_load,
   output logic           wd_status,
   output logic           sys_rst_pulse
);
   logic [N_W-1:0]   nrm_n, rcv_n;
   logic [M_W-1:0]   nrm_m, rcv_m;
   ctl_t             ctl;
   logic [TMO_W-1:0] tmo;
   logic             wr_nrm, wr_rcv, sts_clr;
   logic             armed, expire, tick;
   logic             rcv_act;
   logic             chg_evt, rst_req;

   fcwd_regs #(.N_W(N_W), .M_W(M_W), .TMO_W(TMO_W), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .sts(wd_status), .rdata(cfg_rdata),
      .nrm_n(nrm_n), .nrm_m(nrm_m), .rcv_n(rcv_n), .rcv_m(rcv_m),
      .ctl(ctl), .tmo(tmo), .wr_nrm(wr_nrm), .wr_rcv(wr_rcv), .sts_clr(sts_clr)
   );

   fcwd_prescaler #(.TICK_SHORT(TICK_SHORT), .TICK_LONG(TICK_LONG)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(armed && ctl.wd_en), .restart(wr_nrm),
      .long_sel(ctl.pre_long), .tick(tick)
   );

   fcwd_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .wd_en(ctl.wd_en), .arm(wr_nrm), .tmo(tmo),
      .tick(tick), .sts_clr(sts_clr), .armed(armed), .expire(expire), .sts(wd_status)
   );

   // a frequency change is any divider write or a fall-back to the recovery pair
   assign chg_evt = wr_nrm || wr_rcv || (expire && ctl.rcv_sel);
   assign rst_req = (chg_evt && ctl.rst_chg) || (expire && ctl.rst_to);

   fcwd_pulse #(.LEN(RST_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .req(rst_req), .pulse(sys_rst_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcv_act   <= 1'b0;
         freq_load <= 1'b0;
      end else begin
         freq_load <= chg_evt;
         if (wr_nrm)                      rcv_act <= 1'b0;
         else if (expire && ctl.rcv_sel)  rcv_act <= 1'b1;
      end
   end

   assign div_n = rcv_act ? rcv_n : nrm_n;
   assign div_m = rcv_act ? rcv_m : nrm_m;

   a_r2_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr inside {A_NRM_N, A_NRM_M, A_RCV_N, A_RCV_M}) |=> freq_load);
   a_r4_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.wd_en |-> !tick);
   a_r8_switch_to_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctl.rcv_sel && !wr_nrm && !wr_rcv) |=> (div_n == rcv_n && div_m == rcv_m));
   a_r9_normal_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_nrm |=> !rcv_act);
endmodule

// File: tb/fcwd_top_tb.sv
`timescale 1ns/1ps
module fcwd_top_tb;
   localparam int TS  = 3;
   localparam int TL  = 5;
   localparam int RC  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic [7:0] div_n;
   logic [6:0] div_m;
   logic       freq_load, wd_status, sys_rst_pulse;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fcwd_top #(.TICK_SHORT(TS), .TICK_LONG(TL), .RST_CYC(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .div_n(div_n), .div_m(div_m),
      .freq_load(freq_load), .wd_status(wd_status), .sys_rst_pulse(sys_rst_pulse)
   );

   task automatic chk(input string rq, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic skip(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      skip(3);
      // R1 reset state
      chk("R1 div_n", div_n, 0);
      chk("R1 div_m", div_m, 0);
      chk("R1 freq_load", freq_load, 0);
      chk("R1 status", wd_status, 0);
      chk("R1 rst pulse", sys_rst_pulse, 0);
      rst_n = 1'b1;
      skip(2);

      // R11 readback with truncation
      wr(3'd0, 8'hFF); rd(3'd0, rv); chk("R11 nrm N", rv, 8'hFF);
      wr(3'd1, 8'hFF); rd(3'd1, rv); chk("R11 nrm M", rv, 8'h7F);
      wr(3'd2, 8'hA5); rd(3'd2, rv); chk("R11 rcv N", rv, 8'hA5);
      wr(3'd3, 8'hC3); rd(3'd3, rv); chk("R11 rcv M", rv, 8'h43);
      wr(3'd5, 8'hFF); rd(3'd5, rv); chk("R11 tmo", rv, 8'h1F);
      wr(3'd4, 8'hFF); rd(3'd4, rv); chk("R11 ctrl", rv, 8'h1F);
      wr(3'd4, 8'h00); rd(3'd4, rv); chk("R11 ctrl clear", rv, 8'h00);

      // R2 load strobe for each divider register, none for others
      for (int a = 0; a < 4; a++) begin
         wr(3'(a), 8'h20 + 8'(a));
         skip(1); chk("R2 strobe high", freq_load, 1);
         skip(1); chk("R2 strobe low", freq_load, 0);
      end
      wr(3'd5, 8'h03);
      skip(1); chk("R2 no strobe on timeout write", freq_load, 0);

      // R3 sweep of every timeout value with both tick lengths
      for (int pl = 0; pl < 2; pl++) begin
         for (int t = 0; t < 32; t++) begin
            int cyc;
            cyc = (t + 1) * (pl ? TL : TS);
            wr(3'd4, pl ? 8'h06 : 8'h02);
            wr(3'd5, 8'(t));
            wr(3'd0, 8'(t + 40));
            skip(cyc);     chk("R3 before expiry", wd_status, 0);
            skip(1);       chk("R3 at expiry", wd_status, 1);
            wr(3'd6, 8'h01);
         end
      end

      // R5 status read, write 0 ignored, write 1 clears
      wr(3'd4, 8'h02); wr(3'd5, 8'h00); wr(3'd0, 8'h11);
      skip(4);
      rd(3'd6, rv); chk("R5 read set", rv, 1);
      wr(3'd6, 8'h00); skip(1);
      chk("R5 write 0 no effect", wd_status, 1);
      rd(3'd6, rv); chk("R5 read still set", rv, 1);
      wr(3'd6, 8'h01); skip(1);
      chk("R5 write 1 clears", wd_status, 0);
      // R10 no re-arm without a new divider write
      skip(100); chk("R10 stays idle", wd_status, 0);

      // R4 clearing enable mid-count stops it
      wr(3'd5, 8'h03); wr(3'd0, 8'h12);
      skip(5); wr(3'd4, 8'h00);
      skip(100); chk("R4 stopped", wd_status, 0);
      wr(3'd0, 8'h13); skip(200); chk("R4 disabled no count", wd_status, 0);
      wr(3'd4, 8'h02); wr(3'd0, 8'h14);
      skip(12); chk("R4 full reload before", wd_status, 0);
      skip(1);  chk("R4 full reload at", wd_status, 1);
      wr(3'd6, 8'h01);

      // R6 reset on timeout
      wr(3'd4, 8'h0A); wr(3'd5, 8'h01); wr(3'd0, 8'h15);
      skip(1); chk("R6 no pulse on write", sys_rst_pulse, 0);
      skip(5); chk("R6 before", sys_rst_pulse, 0);
      skip(1); chk("R6 first", sys_rst_pulse, 1);
      skip(3); chk("R6 last", sys_rst_pulse, 1);
      skip(1); chk("R6 ended", sys_rst_pulse, 0);
      wr(3'd6, 8'h01);

      // R7 reset on frequency change
      wr(3'd4, 8'h10); wr(3'd1, 8'h09);
      skip(1); chk("R7 first", sys_rst_pulse, 1);
      skip(3); chk("R7 last", sys_rst_pulse, 1);
      skip(1); chk("R7 ended", sys_rst_pulse, 0);

      // R8 recovery switch
      wr(3'd4, 8'h00);
      wr(3'd1, 8'h10); wr(3'd2, 8'h55); wr(3'd3, 8'h22); wr(3'd5, 8'h00);
      wr(3'd4, 8'h03); wr(3'd0, 8'hA0);
      skip(1); chk("R8 normal active", div_n, 8'hA0);
      skip(2); chk("R8 still normal", div_n, 8'hA0);
      chk("R8 no strobe yet", freq_load, 0);
      skip(1); chk("R8 rcv N", div_n, 8'h55);
      chk("R8 rcv M", div_m, 7'h22);
      chk("R8 switch strobe", freq_load, 1);
      skip(1); chk("R8 strobe ends", freq_load, 0);
      // R9 normal write restores normal pair
      wr(3'd0, 8'hB1);
      skip(1); chk("R9 N", div_n, 8'hB1);
      chk("R9 M", div_m, 7'h10);
      wr(3'd4, 8'h00); wr(3'd6, 8'h01);
      // R8 without recovery select the normal pair stays
      wr(3'd4, 8'h02); wr(3'd0, 8'hC2);
      skip(5); chk("R8 no select keeps N", div_n, 8'hC2);
      chk("R8 timeout seen", wd_status, 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule